// File: doc/BRIEF.md
# External Interrupt Input Controller

This block conditions two external interrupt pins for a small microcontroller core. Each pin passes through a two-flop synchronizer and is then sampled once per peripheral cycle. One peripheral cycle is six peripheral clocks. A peripheral clock is two oscillator periods in standard mode and one in the doubled-clock mode, so a sample is taken every 12 or every 6 oscillator cycles.

For each pin, a type bit selects the trigger. The pin can raise its request on a sampled low level or on a falling edge between two consecutive samples. A detected event sets a request flag, and an enable bit gates that flag onto the interrupt request line. An acknowledge from the core clears a flag in edge mode, while in level mode the flag is left for software to clear. Software can write any flag directly. A low level on either pin drives a wake request straight from the pin, with no clocked path.

Top module: `ext_irq_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, every request flag and every interrupt request reads 0.
- R2: Synchronized pins are sampled only on a strobe that repeats every 12 clocks when `x2_mode_i`=0 and every 6 clocks when `x2_mode_i`=1. A flag set by an event rises in the clock after the sampling strobe.
- R3: With `trig_edge_i[n]`=0 (level mode), a sample that reads low sets `flag_o[n]`. Holding the pin low for longer than one sampling period always sets the flag.
- R4: With `trig_edge_i[n]`=1 (edge mode), `flag_o[n]` is set only when the previous sample was high and the current sample is low. A pin held low does not set the flag again. The previous-sample register starts high after reset.
- R5: In edge mode, an `ack_i[n]` pulse clears `flag_o[n]` in the next clock.
- R6: In level mode, `ack_i[n]` leaves `flag_o[n]` unchanged.
- R7: `irq_o[n]` is `flag_o[n]` AND `enable_i[n]`. A disabled source still sets its flag.
- R8: When `flag_we_i[n]`=1, the flag takes `flag_wdata_i[n]` in the next clock. This write has priority over an acknowledge clear and over a hardware set in the same clock.
- R9: If a hardware set and an acknowledge clear fall in the same clock, the flag is set.
- R10: `wake_o` is 1 whenever any pin is low, including during reset and with no clock edge, and is 0 when all pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| x2_mode_i | input | 1 | 1 = one oscillator period per peripheral clock (sample every 6 clocks) |
| pin_i | input | NUM_SRC | Raw external interrupt pins, active low |
| trig_edge_i | input | NUM_SRC | Trigger type per source: 0 = low level, 1 = falling edge |
| enable_i | input | NUM_SRC | Per-source request enable |
| ack_i | input | NUM_SRC | Vector acknowledge strobe per source |
| flag_we_i | input | NUM_SRC | Software flag write enable per source |
| flag_wdata_i | input | NUM_SRC | Software flag write data |
| flag_o | output | NUM_SRC | Request flags |
| irq_o | output | NUM_SRC | Enabled interrupt requests |
| wake_o | output | 1 | Power-down wake request, any pin low |

## Verification
A wrong sampling counter shows up at the ports as the wrong spacing between successive flag sets. This is measured with a pin held low while software keeps clearing the flag: the spacing should be exactly 12 or 6 clocks. A stale previous-sample register either produces spurious edge-mode flags or misses falling edges, and this becomes visible within one sampling period of a pin transition. Errors in flag priority show up one clock after the conflicting write, acknowledge or set. A behavioural model compared every clock catches any divergence in the same cycle it appears.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_e;

  localparam int unsigned OSC_PER_PCLK_STD = 2;
endpackage

// File: rtl/ext_irq_sample_timer.sv
module ext_irq_sample_timer #(
  parameter int unsigned PCLK_PER_CYCLE = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x2_mode_i,
  output logic strobe_o
);
  import ext_irq_pkg::*;

  localparam int unsigned MAX_PER = PCLK_PER_CYCLE * OSC_PER_PCLK_STD;
  localparam int unsigned CW      = $clog2(MAX_PER + 1);
  localparam logic [CW-1:0] LAST_STD = CW'(MAX_PER - 1);
  localparam logic [CW-1:0] LAST_X2  = CW'(PCLK_PER_CYCLE - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last     = x2_mode_i ? LAST_X2 : LAST_STD;
  // >= so that a mode switch with a large count wraps at once
  assign strobe_o = (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (strobe_o) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  p_strobe_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(MAX_PER));
endmodule

// File: rtl/ext_irq_channel.sv
module ext_irq_channel #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic strobe_i,
  input  logic trig_edge_i,
  input  logic ack_i,
  input  logic flag_we_i,
  input  logic flag_wdata_i,
  output logic flag_o
);
  import ext_irq_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic pin_s, samp_q, flag_q, hw_set;
  trig_e trig;

  assign trig  = trig_e'(trig_edge_i);
  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  // previous sample, reset high so a pin low out of reset counts as an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       samp_q <= 1'b1;
    else if (strobe_i) samp_q <= pin_s;
  end

  always_comb begin
    hw_set = 1'b0;
    if (strobe_i && !pin_s)
      hw_set = (trig == TRIG_LEVEL) ? 1'b1 : samp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           flag_q <= 1'b0;
    else if (flag_we_i)                    flag_q <= flag_wdata_i;
    else if (hw_set)                       flag_q <= 1'b1;
    else if (ack_i && trig == TRIG_FALL)   flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_set_on_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(strobe_i || flag_we_i));
  p_edge_ack_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && trig_edge_i && !flag_we_i && !strobe_i) |=> !flag_q);
  p_level_ack_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && ack_i && !trig_edge_i && !flag_we_i) |=> flag_q);
  p_write_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> (flag_q == $past(flag_wdata_i)));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int unsigned NUM_SRC        = 2,
  parameter int unsigned PCLK_PER_CYCLE = 6,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               x2_mode_i,
  input  logic [NUM_SRC-1:0] pin_i,
  input  logic [NUM_SRC-1:0] trig_edge_i,
  input  logic [NUM_SRC-1:0] enable_i,
  input  logic [NUM_SRC-1:0] ack_i,
  input  logic [NUM_SRC-1:0] flag_we_i,
  input  logic [NUM_SRC-1:0] flag_wdata_i,
  output logic [NUM_SRC-1:0] flag_o,
  output logic [NUM_SRC-1:0] irq_o,
  output logic               wake_o
);
  logic strobe;

  ext_irq_sample_timer #(.PCLK_PER_CYCLE(PCLK_PER_CYCLE)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .x2_mode_i (x2_mode_i),
    .strobe_o  (strobe)
  );

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    ext_irq_channel #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .pin_i        (pin_i[n]),
      .strobe_i     (strobe),
      .trig_edge_i  (trig_edge_i[n]),
      .ack_i        (ack_i[n]),
      .flag_we_i    (flag_we_i[n]),
      .flag_wdata_i (flag_wdata_i[n]),
      .flag_o       (flag_o[n])
    );
  end

  assign irq_o  = flag_o & enable_i;
  // unclocked path: usable with the clock stopped
  assign wake_o = |(~pin_i);

  p_irq_needs_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~flag_o) == '0);
endmodule

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;
  localparam int N = 2;

  logic clk = 1'b0, rst_n = 1'b0, x2 = 1'b0;
  logic [N-1:0] pin = '1, trig = '0, en = '0, ack = '0, we = '0, wd = '0;
  logic [N-1:0] flag, irq;
  logic wake;

  int checks = 0, fails = 0, cyc = 0;
  int m_cnt;
  logic [N-1:0] m_s1, m_s2, m_samp, m_flag;

  always #5 clk = ~clk;

  ext_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .x2_mode_i(x2), .pin_i(pin),
    .trig_edge_i(trig), .enable_i(en), .ack_i(ack), .flag_we_i(we),
    .flag_wdata_i(wd), .flag_o(flag), .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference, one step per clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_s1 = '1; m_s2 = '1; m_samp = '1; m_flag = '0;
    end else begin
      int per;
      bit stb;
      per = x2 ? 6 : 12;
      stb = (m_cnt >= per - 1);
      for (int i = 0; i < N; i++) begin
        bit ev;
        ev = stb && !m_s2[i] && (!trig[i] || m_samp[i]);
        if (we[i])                m_flag[i] = wd[i];
        else if (ev)              m_flag[i] = 1'b1;
        else if (ack[i] && trig[i]) m_flag[i] = 1'b0;
        if (stb) m_samp[i] = m_s2[i];
      end
      m_s2 = m_s1; m_s1 = pin;
      m_cnt = stb ? 0 : m_cnt + 1;
    end
  end

  always @(posedge clk) cyc++;

  always @(negedge clk) if (rst_n) begin
    chk("R2 model flag", flag, m_flag);
    chk("R7 model irq", irq, m_flag & en);
    chk("R10 model wake", wake, ~&pin);
  end

  task automatic cycles(int n); repeat (n) @(negedge clk); endtask

  task automatic sw_write(int i, logic v);
    we[i] = 1'b1; wd[i] = v; @(negedge clk); we[i] = 1'b0;
  endtask

  task automatic wait_rise(int i, output int t);
    t = -1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (flag[i]) begin t = cyc; break; end
    end
  endtask

  task automatic measure_period(logic mode, int exp);
    int t1, t2, t3;
    x2 = mode; trig[0] = 1'b0; pin[0] = 1'b0;
    cycles(20);
    sw_write(0, 1'b0);
    wait_rise(0, t1); sw_write(0, 1'b0);
    wait_rise(0, t2); sw_write(0, 1'b0);
    wait_rise(0, t3);
    chk("R2 sample period", t3 - t2, exp);
    pin[0] = 1'b1; cycles(30); sw_write(0, 1'b0);
  endtask

  initial begin
    bit seen;
    // R10 during reset, no clocked path
    #2 pin[1] = 1'b0; #1 chk("R10 wake in reset", wake, 1);
    pin[1] = 1'b1; #1 chk("R10 wake idle", wake, 0);
    chk("R1 flags in reset", flag, 0);
    chk("R1 irq in reset", irq, 0);
    cycles(3); rst_n = 1'b1; @(negedge clk);
    chk("R1 flags after reset", flag, 0);

    // R3 level mode on source 0
    en[0] = 1'b1; pin[0] = 1'b0; cycles(20);
    chk("R3 level sets flag", flag[0], 1);
    chk("R7 enabled irq", irq[0], 1);
    pin[0] = 1'b1; cycles(30);
    ack[0] = 1'b1; @(negedge clk); ack[0] = 1'b0; cycles(2);
    chk("R6 level ack keeps flag", flag[0], 1);
    sw_write(0, 1'b0);
    chk("R8 sw clear", flag[0], 0);
    cycles(30);
    chk("R3 high pin no set", flag[0], 0);

    // R4 edge mode, disabled source 1
    trig[1] = 1'b1; en[1] = 1'b0; pin[1] = 1'b0; cycles(20);
    chk("R4 edge sets flag", flag[1], 1);
    chk("R7 disabled irq", irq[1], 0);
    en[1] = 1'b1; #1 chk("R7 enable gates irq", irq[1], 1);
    @(negedge clk);
    ack[1] = 1'b1; @(negedge clk); ack[1] = 1'b0;
    chk("R5 edge ack clears", flag[1], 0);
    cycles(40);
    chk("R4 held low no retrigger", flag[1], 0);
    pin[1] = 1'b1; cycles(30); pin[1] = 1'b0; cycles(30);
    chk("R4 second edge", flag[1], 1);

    // R8 write beats ack
    ack[1] = 1'b1; sw_write(1, 1'b1); ack[1] = 1'b0;
    chk("R8 write over ack", flag[1], 1);
    ack[1] = 1'b1; @(negedge clk); ack[1] = 1'b0;
    chk("R5 ack clear again", flag[1], 0);

    // R9 set vs continuous ack
    pin[1] = 1'b1; cycles(30);
    ack[1] = 1'b1; pin[1] = 1'b0; seen = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); if (flag[1]) seen = 1;
    end
    ack[1] = 1'b0;
    chk("R9 set beats ack", seen, 1);
    chk("R5 cleared after set", flag[1], 0);
    pin[1] = 1'b1; cycles(5);

    // R2 sampling period in both modes
    measure_period(1'b0, 12);
    measure_period(1'b1, 6);
    measure_period(1'b0, 12);

    #1 chk("R10 all high", wake, 0);
    pin[0] = 1'b0; #1 chk("R10 pin0 low", wake, 1);
    pin[0] = 1'b1; cycles(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule